// File: doc/BRIEF.md
# Double-Buffered USB OUT Endpoint Controller

This block holds the control and status state of one USB OUT endpoint whose receive store has room for two packets. The serial interface engine reports events to it: an OUT token has started, a packet has ended well, or a packet has ended with a bit-stuffing or CRC fault. The engine also passes the length and data PID of each packet. From these events, the isochronous mode input and a programmable maximum packet size, the block decides whether a packet is stored. It chooses the handshake for the packet and keeps sticky flags for an isochronous overrun, an oversize packet and an isochronous data fault.

The CPU drives a one-cycle write strobe with a command word whose bits act when they are 1. With it the CPU can release the oldest stored packet, discard a packet, clear each flag on its own, and restart the data toggle sequence. The status word can be read at any time. The packet RAM, CRC logic and bus engine are outside the block. The block only counts how many packets are held: zero, one or two.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: After a synchronous active-low reset the endpoint holds no packet, all three flags are 0, and the expected PID is DATA0. The flag `buf_one` is 1 whenever at least one packet is held. The flag `buf_two` is 1 only when two packets are held.
- R2: The occupancy changes only for three reasons: a stored packet, an accepted release command, or an accepted discard command. Each stored packet raises it by one, and the change shows on the flags after the next rising edge.
- R3: In isochronous mode, `tok_start` while two packets are held sets `ovr_flag` one cycle later.
- R4: A packet with `rx_len` greater than `max_len` sets `big_flag` and is not stored. In non-isochronous mode its handshake is STALL, and this choice takes priority over NAK.
- R5: In isochronous mode, `rx_bad` sets `err_flag` and nothing is stored. In non-isochronous mode, `rx_bad` changes no flag and no occupancy.
- R6: Each flag is cleared only by writing 1 to its own clear bit: bit 1 clears overrun, bit 2 clears oversize, bit 3 clears data error. Writing 0 has no effect. A set and a clear in the same cycle leave the flag at 1.
- R7: Release (command bit 0) lowers the occupancy by one while `buf_one` is 1, and is ignored while the buffer is empty.
- R8: Discard (command bit 5) lowers the occupancy by one while `buf_one` is 1, and is ignored while the buffer is empty. From two packets it leaves only the newer one. Release and discard written together remove one packet.
- R9: Writing 1 to command bit 4 makes the expected PID DATA0 (`exp_data1`=0). This takes priority over a toggle caused by a packet in the same cycle.
- R10: In non-isochronous mode, `hs_valid` pulses one cycle after `rx_ok` with `hs_sel` = 2'b10 (STALL) for an oversize packet, 2'b01 (NAK) when two packets are held, and 2'b00 (ACK) otherwise. A packet whose PID differs from the expected one is acknowledged but not stored and does not flip the toggle. A stored packet flips the toggle. In isochronous mode there is no handshake, the PID is ignored, and the toggle does not change.
- R11: When a packet arrives in the same cycle as an accepted release or discard, both take effect. The packet is judged against the occupancy held before the removal.
- R12: `reg_rdata` bits are: 0 `buf_two`, 1 `buf_one`, 2 overrun, 3 oversize, 4 data error, 5 expected PID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_start | input | 1 | OUT token addressed to this endpoint has begun |
| rx_ok | input | 1 | Packet ended with no error |
| rx_bad | input | 1 | Packet ended with a bit-stuffing or CRC error |
| rx_len | input | LEN_W | Length of the packet that ended |
| rx_data1 | input | 1 | Packet PID is DATA1 (0 means DATA0) |
| iso_mode | input | 1 | Endpoint runs isochronous transfers |
| max_len | input | LEN_W | Largest allowed packet length |
| reg_wr | input | 1 | CPU command write strobe |
| reg_wdata | input | 6 | Command bits, each acting when 1 |
| reg_rdata | output | 6 | Status word |
| buf_one | output | 1 | At least one packet held |
| buf_two | output | 1 | Two packets held |
| ovr_flag | output | 1 | Isochronous overrun seen |
| big_flag | output | 1 | Oversize packet seen |
| err_flag | output | 1 | Isochronous data error seen |
| exp_data1 | output | 1 | Next packet expected as DATA1 |
| hs_valid | output | 1 | Handshake choice valid this cycle |
| hs_sel | output | 2 | 00 ACK, 01 NAK, 10 STALL |

## Verification
The bench builds the block with `LEN_W` = 4 and sets `max_len` to 8 during the run. This makes lengths both below and above the limit common under random stimulus, so the oversize path is exercised often. With the small length width, the comparison of `rx_len` against `max_len` also runs through every value. Since the occupancy limit is only two packets, a few receives are enough to reach a full buffer. That brings NAK, isochronous overrun, discard of the older packet, and receive-with-removal in the same cycle into reach in every stretch of the run.

// File: rtl/usb_out_ep_pkg.sv
// Shared types and command/status bit layout for the OUT endpoint controller.
// Assumes the command word and status word are both six bits wide.
package usb_out_ep_pkg;

    localparam int CMD_W  = 6;
    localparam int STAT_W = 6;

    // Handshake selection presented to the bus engine.
    typedef enum logic [1:0] {
        HS_ACK   = 2'b00,
        HS_NAK   = 2'b01,
        HS_STALL = 2'b10
    } hs_e;

    // Command word: bit 0 release, 1..3 flag clears, 4 toggle restart, 5 discard.
    typedef struct packed {
        logic discard;
        logic tgl_init;
        logic clr_err;
        logic clr_big;
        logic clr_ovr;
        logic release_pkt;
    } cmd_t;

    // Flag vector indices used by the sticky flag bank.
    localparam int FLG_OVR = 0;
    localparam int FLG_BIG = 1;
    localparam int FLG_ERR = 2;
    localparam int FLG_N   = 3;

endpackage

// File: rtl/usb_out_occ.sv
// Occupancy counter for the packet store.
// Counts held packets between 0 and DEPTH. A removal request is honoured only
// when the count is non-zero. Assumes the caller never pushes into a full store
// (the receive judge refuses such packets).
module usb_out_occ #(
    parameter int DEPTH = 2,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop_req,
    output logic [OCC_W-1:0] occ
);

    localparam logic [OCC_W-1:0] EMPTY = '0;
    localparam logic [OCC_W-1:0] FULL  = OCC_W'(DEPTH);

    logic             pop_ok;
    logic [OCC_W-1:0] occ_q;

    assign pop_ok = pop_req && (occ_q != EMPTY);

    // Count up on a stored packet and down on an accepted removal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= EMPTY;
        end else begin
            occ_q <= occ_q + OCC_W'(push) - OCC_W'(pop_ok);
        end
    end

    assign occ = occ_q;

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= FULL);  // R1
    AST_OCC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop_req) |=> $stable(occ_q));  // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push && occ_q == EMPTY) |=> (occ_q == EMPTY));  // R7

endmodule

// File: rtl/usb_out_rx_judge.sv
// Receive judge: classifies the packet that ends this cycle.
// Purely combinational. Assumes occ is the count before any removal in the
// same cycle, so a packet is always judged against the store as it stands.
module usb_out_rx_judge
    import usb_out_ep_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int DEPTH = 2,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             rx_ok,
    input  logic             rx_bad,
    input  logic [LEN_W-1:0] rx_len,
    input  logic [LEN_W-1:0] max_len,
    input  logic             rx_data1,
    input  logic             iso_mode,
    input  logic [OCC_W-1:0] occ,
    input  logic             exp_data1,
    output logic             push,
    output logic             set_big,
    output logic             set_err,
    output logic             tgl_flip,
    output logic             hs_req,
    output hs_e              hs_code
);

    localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

    logic too_long;
    logic full;
    logic pid_match;

    assign too_long  = rx_len > max_len;
    assign full      = occ == FULL;
    assign pid_match = rx_data1 == exp_data1;

    // Decide store, flag updates and handshake for the ending packet.
    always_comb begin
        push     = 1'b0;
        set_big  = 1'b0;
        set_err  = 1'b0;
        tgl_flip = 1'b0;
        hs_req   = 1'b0;
        hs_code  = HS_ACK;
        if (rx_bad) begin
            set_err = iso_mode;
        end else if (rx_ok) begin
            hs_req = !iso_mode;
            if (too_long) begin
                set_big = 1'b1;
                hs_code = HS_STALL;
            end else if (full) begin
                hs_code = HS_NAK;
            end else if (iso_mode) begin
                push = 1'b1;
            end else if (pid_match) begin
                push     = 1'b1;
                tgl_flip = 1'b1;
            end
        end
    end

endmodule

// File: rtl/usb_out_flags.sv
// Bank of sticky status flags.
// Each flag is set by its own event and cleared by its own clear strobe;
// a set in the same cycle as a clear keeps the flag at 1.
module usb_out_flags #(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    output logic [NFLAG-1:0] flag
);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        logic q;

        // Hold the flag until its clear strobe, with set taking priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= 1'b0;
            end else if (set[i]) begin
                q <= 1'b1;
            end else if (clr[i]) begin
                q <= 1'b0;
            end
        end

        assign flag[i] = q;

        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (q && !clr[i]) |=> q);  // R6
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q);  // R6
    end

endmodule

// File: rtl/usb_out_ep_ctrl.sv
// Double-buffered OUT endpoint controller (top).
// Joins the occupancy counter, receive judge and flag bank, holds the data
// toggle and the registered handshake choice, and decodes CPU commands.
// Assumes rx_ok and rx_bad are single-cycle end-of-packet strobes and that
// rx_len, rx_data1 are valid in that cycle.
module usb_out_ep_ctrl
    import usb_out_ep_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_start,
    input  logic              rx_ok,
    input  logic              rx_bad,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_data1,
    input  logic              iso_mode,
    input  logic [LEN_W-1:0]  max_len,
    input  logic              reg_wr,
    input  logic [CMD_W-1:0]  reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic              buf_one,
    output logic              buf_two,
    output logic              ovr_flag,
    output logic              big_flag,
    output logic              err_flag,
    output logic              exp_data1,
    output logic              hs_valid,
    output logic [1:0]        hs_sel
);

    localparam int BUF_DEPTH = 2;
    localparam int OCC_W     = $clog2(BUF_DEPTH + 1);
    localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(BUF_DEPTH);

    cmd_t             cmd;
    logic [OCC_W-1:0] occ;
    logic             push;
    logic             set_big;
    logic             set_err;
    logic             tgl_flip;
    logic             hs_req;
    hs_e              hs_code;
    logic             set_ovr;
    logic [FLG_N-1:0] flg_set;
    logic [FLG_N-1:0] flg_clr;
    logic [FLG_N-1:0] flg;
    logic             tgl_q;
    logic             hs_valid_q;
    hs_e              hs_sel_q;

    // Commands act only in the cycle of the write strobe.
    assign cmd = reg_wr ? cmd_t'(reg_wdata) : '0;

    usb_out_occ #(
        .DEPTH(BUF_DEPTH)
    ) i_occ (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .pop_req(cmd.release_pkt | cmd.discard),
        .occ    (occ)
    );

    usb_out_rx_judge #(
        .LEN_W(LEN_W),
        .DEPTH(BUF_DEPTH)
    ) i_judge (
        .rx_ok    (rx_ok),
        .rx_bad   (rx_bad),
        .rx_len   (rx_len),
        .max_len  (max_len),
        .rx_data1 (rx_data1),
        .iso_mode (iso_mode),
        .occ      (occ),
        .exp_data1(tgl_q),
        .push     (push),
        .set_big  (set_big),
        .set_err  (set_err),
        .tgl_flip (tgl_flip),
        .hs_req   (hs_req),
        .hs_code  (hs_code)
    );

    assign set_ovr = iso_mode && tok_start && (occ == OCC_FULL);

    // Route events and clears into the flag bank.
    always_comb begin
        flg_set          = '0;
        flg_clr          = '0;
        flg_set[FLG_OVR] = set_ovr;
        flg_set[FLG_BIG] = set_big;
        flg_set[FLG_ERR] = set_err;
        flg_clr[FLG_OVR] = cmd.clr_ovr;
        flg_clr[FLG_BIG] = cmd.clr_big;
        flg_clr[FLG_ERR] = cmd.clr_err;
    end

    usb_out_flags #(
        .NFLAG(FLG_N)
    ) i_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (flg_set),
        .clr  (flg_clr),
        .flag (flg)
    );

    // Data toggle: restart command wins over a flip from a stored packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else if (cmd.tgl_init) begin
            tgl_q <= 1'b0;
        end else if (tgl_flip) begin
            tgl_q <= !tgl_q;
        end
    end

    // Register the handshake choice for the cycle after the packet ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid_q <= 1'b0;
            hs_sel_q   <= HS_ACK;
        end else begin
            hs_valid_q <= hs_req;
            if (hs_req) begin
                hs_sel_q <= hs_code;
            end
        end
    end

    assign buf_one   = occ != '0;
    assign buf_two   = occ == OCC_FULL;
    assign ovr_flag  = flg[FLG_OVR];
    assign big_flag  = flg[FLG_BIG];
    assign err_flag  = flg[FLG_ERR];
    assign exp_data1 = tgl_q;
    assign hs_valid  = hs_valid_q;
    assign hs_sel    = hs_sel_q;
    assign reg_rdata = {tgl_q, flg[FLG_ERR], flg[FLG_BIG], flg[FLG_OVR], buf_one, buf_two};

    AST_STS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        buf_two |-> buf_one);  // R1
    AST_OVR_ON_FULL_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_mode && tok_start && buf_two) |=> ovr_flag);  // R3
    AST_STALL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_sel == HS_STALL) |-> big_flag);  // R4
    AST_TGL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[4]) |=> !exp_data1);  // R9
    AST_ISO_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_mode && rx_ok) |=> !hs_valid);  // R10
    AST_ISO_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_mode && rx_bad) |=> err_flag);  // R5

endmodule

// File: tb/test_usb_out_ep_ctrl.sv
`timescale 1ns/1ps
module test_usb_out_ep_ctrl;

    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tok_start = 1'b0;
    logic          rx_ok = 1'b0;
    logic          rx_bad = 1'b0;
    logic [LW-1:0] rx_len = '0;
    logic          rx_data1 = 1'b0;
    logic          iso_mode = 1'b0;
    logic [LW-1:0] max_len = 4'd8;
    logic          reg_wr = 1'b0;
    logic [5:0]    reg_wdata = '0;
    logic [5:0]    reg_rdata;
    logic          buf_one, buf_two, ovr_flag, big_flag, err_flag, exp_data1, hs_valid;
    logic [1:0]    hs_sel;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    usb_out_ep_ctrl #(.LEN_W(LW)) i_usb_out_ep_ctrl (
        .clk(clk), .rst_n(rst_n), .tok_start(tok_start), .rx_ok(rx_ok),
        .rx_bad(rx_bad), .rx_len(rx_len), .rx_data1(rx_data1),
        .iso_mode(iso_mode), .max_len(max_len), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_one(buf_one),
        .buf_two(buf_two), .ovr_flag(ovr_flag), .big_flag(big_flag),
        .err_flag(err_flag), .exp_data1(exp_data1), .hs_valid(hs_valid),
        .hs_sel(hs_sel)
    );

    // Reference model state
    int m_occ = 0;
    bit m_ovr = 0, m_big = 0, m_err = 0, m_tgl = 0, m_hsv = 0, started = 0;
    int m_hs = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model stepped on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_occ = 0; m_ovr = 0; m_big = 0; m_err = 0; m_tgl = 0; m_hsv = 0; m_hs = 0;
            started = 1;
        end else begin
            int pre;
            bit rem, push, s_big, s_err, flip, hv, s_ovr;
            int hc;
            pre = m_occ;
            rem = reg_wr && (reg_wdata[0] || reg_wdata[5]) && pre > 0;
            push = 0; s_big = 0; s_err = 0; flip = 0; hv = 0; hc = m_hs;
            if (rx_bad) begin
                s_err = iso_mode;
            end else if (rx_ok) begin
                if (rx_len > max_len) begin s_big = 1; hv = !iso_mode; hc = 2; end
                else if (pre == 2) begin hv = !iso_mode; hc = 1; end
                else if (iso_mode) push = 1;
                else begin
                    hv = 1; hc = 0;
                    if (rx_data1 == m_tgl) begin push = 1; flip = 1; end
                end
            end
            if (!hv) hc = m_hs;
            s_ovr = iso_mode && tok_start && pre == 2;
            m_occ = pre + int'(push) - int'(rem);
            m_ovr = s_ovr | (m_ovr & !(reg_wr && reg_wdata[1]));
            m_big = s_big | (m_big & !(reg_wr && reg_wdata[2]));
            m_err = s_err | (m_err & !(reg_wr && reg_wdata[3]));
            if (reg_wr && reg_wdata[4]) m_tgl = 0;
            else if (flip) m_tgl = !m_tgl;
            m_hsv = hv;
            m_hs = hc;
        end
    end

    // Compare every output against the model between edges
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R1 buf_one", int'(buf_one), int'(m_occ >= 1));
            chk("R1 buf_two", int'(buf_two), int'(m_occ == 2));
            chk("R3 ovr_flag", int'(ovr_flag), int'(m_ovr));
            chk("R4 big_flag", int'(big_flag), int'(m_big));
            chk("R5 err_flag", int'(err_flag), int'(m_err));
            chk("R9 exp_data1", int'(exp_data1), int'(m_tgl));
            chk("R10 hs_valid", int'(hs_valid), int'(m_hsv));
            if (m_hsv) chk("R10 hs_sel", int'(hs_sel), m_hs);
            chk("R12 reg_rdata", int'(reg_rdata),
                int'({m_tgl, m_err, m_big, m_ovr, (m_occ >= 1), (m_occ == 2)}));
        end
    end

    // One cycle of stimulus, applied just after a falling edge
    task automatic drive(input bit tok, input bit ok, input bit bad, input int len,
                         input bit d1, input bit wr, input logic [5:0] wd);
        tok_start = tok; rx_ok = ok; rx_bad = bad; rx_len = LW'(len);
        rx_data1 = d1; reg_wr = wr; reg_wdata = wd;
        @(negedge clk);
        tok_start = 0; rx_ok = 0; rx_bad = 0; reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic pkt(input int len, input bit d1);
        drive(0, 1, 0, len, d1, 0, 6'b0);
    endtask

    task automatic cmd(input logic [5:0] wd);
        drive(0, 0, 0, 0, 0, 1, wd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset status", int'(reg_rdata), 0);

        pkt(4, 0);
        chk("R2 one stored", int'(reg_rdata), 6'b100010);
        chk("R10 ack", int'(hs_sel), 0);
        pkt(4, 0);
        chk("R10 pid mismatch not stored", int'(reg_rdata), 6'b100010);
        pkt(8, 1);
        chk("R2 two stored", int'(reg_rdata), 6'b000011);
        pkt(3, 0);
        chk("R10 nak when full", int'(hs_sel), 1);
        pkt(9, 0);
        chk("R4 stall over nak", int'(hs_sel), 2);
        chk("R4 stall flag", int'(reg_rdata), 6'b001011);
        cmd(6'b000000);
        chk("R6 write zero ignored", int'(reg_rdata), 6'b001011);
        cmd(6'b000100);
        chk("R6 own clear", int'(reg_rdata), 6'b000011);
        cmd(6'b100000);
        chk("R8 discard older of two", int'(reg_rdata), 6'b000010);
        drive(0, 1, 0, 2, 0, 1, 6'b000001);
        chk("R11 receive with release", int'(reg_rdata), 6'b100010);
        cmd(6'b100001);
        chk("R8 release and discard remove one", int'(reg_rdata), 6'b100000);
        cmd(6'b000001);
        chk("R7 release when empty ignored", int'(reg_rdata), 6'b100000);
        cmd(6'b100000);
        chk("R8 discard when empty ignored", int'(reg_rdata), 6'b100000);
        drive(0, 1, 0, 1, 1, 1, 6'b010000);
        chk("R9 restart beats flip", int'(reg_rdata), 6'b000010);
        cmd(6'b000001);
        chk("R7 release of one", int'(reg_rdata), 6'b000000);

        iso_mode = 1;
        pkt(5, 1);
        chk("R10 iso stores any pid", int'(reg_rdata), 6'b000010);
        chk("R10 iso no handshake", int'(hs_valid), 0);
        pkt(5, 1);
        drive(1, 0, 0, 0, 0, 0, 6'b0);
        chk("R3 overrun", int'(reg_rdata), 6'b000111);
        drive(0, 0, 1, 3, 0, 0, 6'b0);
        chk("R5 iso data error", int'(reg_rdata), 6'b010111);
        drive(1, 0, 0, 0, 0, 1, 6'b000010);
        chk("R6 set beats clear", int'(ovr_flag), 1);
        cmd(6'b001010);
        chk("R6 two clears", int'(reg_rdata), 6'b000011);
        iso_mode = 0;
        drive(0, 0, 1, 3, 0, 0, 6'b0);
        chk("R5 non-iso error ignored", int'(reg_rdata), 6'b000011);

        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 0) iso_mode = $urandom_range(0, 1);
            drive($urandom_range(0, 5) == 0, $urandom_range(0, 2) == 0,
                  $urandom_range(0, 9) == 0, $urandom_range(0, 15),
                  $urandom_range(0, 1), $urandom_range(0, 3) == 0,
                  6'($urandom_range(0, 63)));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule